// File: doc/BRIEF.md
# Fixed Off-Time Mixed-Decay PWM Chopping Timer

This block sequences the current-chopping cycle of one bridge of a stepper driver. It runs on the oscillator clock. When drive begins, it ignores the current-sense comparator for a programmed blanking interval. Once blanking is over, a comparator trip ends the on-time and starts a fixed off-time. The off-time opens in fast decay for its own programmed length and finishes in slow decay. When the off-time expires, drive resumes with a new blanking interval.

The bridge gate logic uses three mutually exclusive indications: drive on, fast decay and slow decay. Clearing the run bit or programming a zero current code parks the bridge with all three indications low. A change of the direction bit restarts blanking at once, so switching transients after a reversal cannot end the on-time early. The analog comparison and the current DAC are outside this block. It only sees the digital comparator result and the current code.

Top module: `pwm_chop_timer`

## Requirements
- R1: While `rst_n` is low, and in the first cycle after it is released, `drive_on`, `fast_decay` and `slow_decay` are all 0.
- R2: If, at a clock edge, `run_en` is 0 or `dac_code` is all zeros, all three outputs are 0 in the following cycle. When the bridge is next enabled, it starts again with a blanking interval.
- R3: When the bridge is enabled from rest, or after an off-time, a blanking interval follows with `drive_on` = 1. It lasts 4·(B+1) cycles, where B is the unsigned value of `blank_code` (B = 0..3 gives 4, 8, 12 or 16 cycles).
- R4: A `trip` input of 1 during a blanking interval has no effect: `drive_on` stays 1 until the interval ends.
- R5: After blanking, `drive_on` stays 1 until `trip` is sampled as 1. From the next cycle the off-time runs, with `drive_on` = 0.
- R6: The off-time lasts exactly 8·N+7 cycles, where N is the unsigned value of `off_code` (0..31). Blanking follows it, with `drive_on` = 1.
- R7: During the off-time, `fast_decay` = 1 for the first 8·M+7 cycles, where M is the unsigned value of `fast_code` (0..15). `slow_decay` = 1 for the cycles after those.
- R8: If 8·M+7 is at least 8·N+7, `fast_decay` stays 1 for the whole off-time and `slow_decay` stays 0.
- R9: If `phase` differs from its value at the previous clock edge while the bridge is enabled, the next cycle is the first cycle of a new blanking interval. This applies even when an off-time is in progress.
- R10: At most one of `drive_on`, `fast_decay` and `slow_decay` is 1 in any cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Oscillator clock |
| rst_n | input | 1 | Synchronous active-low reset |
| run_en | input | 1 | 1 = bridge may run; 0 = idle, all outputs low |
| dac_code | input | 6 | Current level code; zero disables the bridge |
| phase | input | 1 | Current direction bit; a change restarts blanking |
| blank_code | input | 2 | Blanking length select, 4·(code+1) cycles |
| off_code | input | 5 | Off-time length, 8·code+7 cycles |
| fast_code | input | 4 | Fast-decay portion of the off-time, 8·code+7 cycles |
| trip | input | 1 | Digital current-sense comparator result |
| drive_on | output | 1 | Bridge driving the load (blanking or on-time) |
| fast_decay | output | 1 | Off-time, fast-decay portion |
| slow_decay | output | 1 | Off-time, slow-decay portion |

## Verification
The assertions that bound the off-time and the fast/slow split assume that `off_code` and `fast_code` hold steady for a whole off-time. The lengths are read combinationally, so a code change in mid-interval would move the boundary. The stimulus changes these codes, and `blank_code`, only while `run_en` is 0. `trip` and `phase` are treated as free-running and may change in any cycle. The stimulus toggles `phase` during blanking, on-time and off-time alike, and holds `trip` high through blanking to show that it is ignored there.

// File: rtl/pwm_chop_pkg.sv
// Shared types and helpers for the PWM chopping timer.
// Assumes: interval lengths fit the counter width chosen by the top module.
package pwm_chop_pkg;

    // Sequencer states of one bridge
    typedef enum logic [1:0] {
        ST_REST  = 2'd0,
        ST_BLANK = 2'd1,
        ST_DRIVE = 2'd2,
        ST_OFF   = 2'd3
    } chop_st_t;

    // Length of a code-scaled interval: (code << shift) + base
    function automatic int unsigned scaled_span(input int unsigned code,
                                                input int unsigned shift,
                                                input int unsigned base);
        return (code << shift) + base;
    endfunction

endpackage

// File: rtl/chop_phase_det.sv
// Detects a change of the direction bit between consecutive clock edges.
// Assumes: phase is synchronous to clk. The stored value resets to 0.
module chop_phase_det (
    input  logic clk,
    input  logic rst_n,
    input  logic phase,
    output logic flip
);
    logic phase_q;

    // Remember the direction bit sampled at the last edge
    always_ff @(posedge clk) begin
        if (!rst_n) phase_q <= 1'b0;
        else        phase_q <= phase;
    end

    // A difference from the stored value is a direction change
    always_comb flip = phase ^ phase_q;
endmodule

// File: rtl/chop_span_calc.sv
// Turns the three length codes into interval lengths in clock cycles.
// Assumes: CNT_W holds the largest off, fast and blank length.
module chop_span_calc #(
    parameter int OFF_W      = 5,
    parameter int FAST_W     = 4,
    parameter int BLANK_W    = 2,
    parameter int STEP_LOG2  = 3,
    parameter int SPAN_BASE  = 7,
    parameter int BLANK_UNIT = 4,
    parameter int CNT_W      = 8
) (
    input  logic [OFF_W-1:0]   off_code,
    input  logic [FAST_W-1:0]  fast_code,
    input  logic [BLANK_W-1:0] blank_code,
    output logic [CNT_W-1:0]   off_len,
    output logic [CNT_W-1:0]   fast_len,
    output logic [CNT_W-1:0]   blank_len
);
    // Step-scaled lengths with a fixed base, and a linear blank length
    always_comb begin
        off_len   = (CNT_W'(off_code)  << STEP_LOG2) + CNT_W'(SPAN_BASE);
        fast_len  = (CNT_W'(fast_code) << STEP_LOG2) + CNT_W'(SPAN_BASE);
        blank_len = (CNT_W'(blank_code) + CNT_W'(1)) * CNT_W'(BLANK_UNIT);
    end
endmodule

// File: rtl/chop_seq.sv
// State and interval counter of the chop cycle: rest, blank, drive, off.
// Assumes: blank_len and off_len are at least 1. Disable beats restart,
// and restart beats the normal sequence.
module chop_seq
    import pwm_chop_pkg::*;
#(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             enable,
    input  logic             restart,
    input  logic             trip,
    input  logic [CNT_W-1:0] blank_len,
    input  logic [CNT_W-1:0] off_len,
    output chop_st_t         st,
    output logic [CNT_W-1:0] cnt
);
    chop_st_t         nxt_st;
    logic [CNT_W-1:0] nxt_cnt;

    // Next state and counter from the current state and inputs
    always_comb begin
        nxt_st  = st;
        nxt_cnt = cnt + CNT_W'(1);
        if (!enable) begin
            nxt_st  = ST_REST;
            nxt_cnt = '0;
        end else if (st == ST_REST || restart) begin
            nxt_st  = ST_BLANK;
            nxt_cnt = '0;
        end else begin
            unique case (st)
                ST_BLANK: begin
                    if (cnt == blank_len - CNT_W'(1)) begin
                        nxt_st  = ST_DRIVE;
                        nxt_cnt = '0;
                    end
                end
                ST_DRIVE: begin
                    nxt_cnt = '0;
                    if (trip) nxt_st = ST_OFF;
                end
                ST_OFF: begin
                    if (cnt == off_len - CNT_W'(1)) begin
                        nxt_st  = ST_BLANK;
                        nxt_cnt = '0;
                    end
                end
                default: begin
                    nxt_st  = ST_REST;
                    nxt_cnt = '0;
                end
            endcase
        end
    end

    // State and counter registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st  <= ST_REST;
            cnt <= '0;
        end else begin
            st  <= nxt_st;
            cnt <= nxt_cnt;
        end
    end
endmodule

// File: rtl/chop_decay_sel.sv
// Decodes sequencer state into the gate-logic indications.
// Assumes: cnt counts from 0 at the first off-time cycle.
module chop_decay_sel
    import pwm_chop_pkg::*;
#(
    parameter int CNT_W = 8
) (
    input  chop_st_t         st,
    input  logic [CNT_W-1:0] cnt,
    input  logic [CNT_W-1:0] fast_len,
    output logic             drive_on,
    output logic             fast_decay,
    output logic             slow_decay,
    output logic             in_blank
);
    // Fast decay for the leading part of the off-time, slow for the rest
    always_comb begin
        in_blank   = (st == ST_BLANK);
        drive_on   = (st == ST_BLANK) || (st == ST_DRIVE);
        fast_decay = (st == ST_OFF) && (cnt <  fast_len);
        slow_decay = (st == ST_OFF) && (cnt >= fast_len);
    end
endmodule

// File: rtl/pwm_chop_timer.sv
// Fixed off-time mixed-decay chopping timer for one bridge.
// Assumes: all inputs are synchronous to the oscillator clock, and the
// length codes hold steady while an interval runs.
module pwm_chop_timer
    import pwm_chop_pkg::*;
#(
    parameter int OFF_W      = 5,
    parameter int FAST_W     = 4,
    parameter int BLANK_W    = 2,
    parameter int DAC_W      = 6,
    parameter int STEP_LOG2  = 3,
    parameter int SPAN_BASE  = 7,
    parameter int BLANK_UNIT = 4
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               run_en,
    input  logic [DAC_W-1:0]   dac_code,
    input  logic               phase,
    input  logic [BLANK_W-1:0] blank_code,
    input  logic [OFF_W-1:0]   off_code,
    input  logic [FAST_W-1:0]  fast_code,
    input  logic               trip,
    output logic               drive_on,
    output logic               fast_decay,
    output logic               slow_decay
);
    localparam int OFF_MAX   = scaled_span((2**OFF_W) - 1, STEP_LOG2, SPAN_BASE);
    localparam int FAST_MAX  = scaled_span((2**FAST_W) - 1, STEP_LOG2, SPAN_BASE);
    localparam int BLANK_MAX = (2**BLANK_W) * BLANK_UNIT;
    localparam int SPAN_MAX  = (OFF_MAX > FAST_MAX) ?
                               ((OFF_MAX > BLANK_MAX) ? OFF_MAX : BLANK_MAX) :
                               ((FAST_MAX > BLANK_MAX) ? FAST_MAX : BLANK_MAX);
    localparam int CNT_W     = $clog2(SPAN_MAX + 1);

    logic             enable;
    logic             flip;
    logic             in_blank;
    logic [CNT_W-1:0] off_len, fast_len, blank_len, cnt;
    chop_st_t         st;

    // The bridge runs only when allowed and given a nonzero current code
    always_comb enable = run_en && (dac_code != '0);

    chop_phase_det u_phase (
        .clk   (clk),
        .rst_n (rst_n),
        .phase (phase),
        .flip  (flip)
    );

    chop_span_calc #(
        .OFF_W      (OFF_W),
        .FAST_W     (FAST_W),
        .BLANK_W    (BLANK_W),
        .STEP_LOG2  (STEP_LOG2),
        .SPAN_BASE  (SPAN_BASE),
        .BLANK_UNIT (BLANK_UNIT),
        .CNT_W      (CNT_W)
    ) u_span (
        .off_code   (off_code),
        .fast_code  (fast_code),
        .blank_code (blank_code),
        .off_len    (off_len),
        .fast_len   (fast_len),
        .blank_len  (blank_len)
    );

    chop_seq #(.CNT_W(CNT_W)) u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .enable    (enable),
        .restart   (flip),
        .trip      (trip),
        .blank_len (blank_len),
        .off_len   (off_len),
        .st        (st),
        .cnt       (cnt)
    );

    chop_decay_sel #(.CNT_W(CNT_W)) u_dec (
        .st         (st),
        .cnt        (cnt),
        .fast_len   (fast_len),
        .drive_on   (drive_on),
        .fast_decay (fast_decay),
        .slow_decay (slow_decay),
        .in_blank   (in_blank)
    );
endmodule

// File: rtl/pwm_chop_chk.sv
// Assertion checker for the chopping timer, bound to the top module.
// Assumes: off_code and fast_code hold steady during an off-time.
module pwm_chop_chk #(
    parameter int OFF_W     = 5,
    parameter int FAST_W    = 4,
    parameter int DAC_W     = 6,
    parameter int STEP_LOG2 = 3,
    parameter int SPAN_BASE = 7
) (
    input logic              clk,
    input logic              rst_n,
    input logic              run_en,
    input logic [DAC_W-1:0]  dac_code,
    input logic              phase,
    input logic [OFF_W-1:0]  off_code,
    input logic [FAST_W-1:0] fast_code,
    input logic              trip,
    input logic              in_blank,
    input logic              drive_on,
    input logic              fast_decay,
    input logic              slow_decay
);
    int unsigned off_run;
    int unsigned off_lim, fast_lim;
    logic        en;

    // Cycles spent so far in the current off-time
    always_ff @(posedge clk) begin
        if (!rst_n)                       off_run <= 0;
        else if (fast_decay || slow_decay) off_run <= off_run + 1;
        else                              off_run <= 0;
    end

    // Expected lengths and enable, worked out independently
    always_comb begin
        off_lim  = (int'(off_code)  << STEP_LOG2) + SPAN_BASE;
        fast_lim = (int'(fast_code) << STEP_LOG2) + SPAN_BASE;
        en       = run_en && (dac_code != '0);
    end

    // R10
    excl_out_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({drive_on, fast_decay, slow_decay}));

    // R2
    park_out_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> !(drive_on || fast_decay || slow_decay));

    // R4
    blank_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (en && in_blank && trip && $past(rst_n) && phase == $past(phase)) |=> drive_on);

    // R5
    trip_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (en && drive_on && !in_blank && trip && $past(rst_n) && phase == $past(phase))
        |=> (fast_decay || slow_decay));

    // R9
    dir_blank_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (en && $past(rst_n) && phase != $past(phase)) |=> (in_blank && drive_on));

    // R6
    off_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (fast_decay || slow_decay) |-> (off_run < off_lim));

    // R7
    slow_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
        slow_decay |-> (off_run >= fast_lim));
endmodule

bind pwm_chop_timer pwm_chop_chk #(
    .OFF_W     (OFF_W),
    .FAST_W    (FAST_W),
    .DAC_W     (DAC_W),
    .STEP_LOG2 (STEP_LOG2),
    .SPAN_BASE (SPAN_BASE)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .run_en     (run_en),
    .dac_code   (dac_code),
    .phase      (phase),
    .off_code   (off_code),
    .fast_code  (fast_code),
    .trip       (trip),
    .in_blank   (in_blank),
    .drive_on   (drive_on),
    .fast_decay (fast_decay),
    .slow_decay (slow_decay)
);

// File: tb/tb_pwm_chop_timer.sv
// Bench: behavioural cycle model compared with the design every clock.
module tb_pwm_chop_timer;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       run_en = 1'b0;
    logic [5:0] dac_code = '0;
    logic       phase = 1'b0;
    logic [1:0] blank_code = '0;
    logic [4:0] off_code = '0;
    logic [3:0] fast_code = '0;
    logic       trip = 1'b0;
    logic       drive_on, fast_decay, slow_decay;

    int    n_cmp = 0;
    int    n_bad = 0;
    string cur_req = "R1";
    bit    started = 0;
    bit    done = 0;

    // model state: 0 rest, 1 blanking, 2 driving, 3 off-time
    int m_mode = 0;
    int m_age = 0;
    bit m_dir = 0;

    always #10 clk = ~clk;

    pwm_chop_timer dut (
        .clk(clk), .rst_n(rst_n), .run_en(run_en), .dac_code(dac_code),
        .phase(phase), .blank_code(blank_code), .off_code(off_code),
        .fast_code(fast_code), .trip(trip), .drive_on(drive_on),
        .fast_decay(fast_decay), .slow_decay(slow_decay)
    );

    // Reference model advance at each rising edge
    always @(posedge clk) begin
        bit dir_chg;
        started = 1;
        if (!rst_n) begin
            m_mode = 0; m_age = 0; m_dir = 0;
        end else begin
            dir_chg = (phase != m_dir);
            m_dir = phase;
            if (!(run_en && dac_code != 0)) begin
                m_mode = 0; m_age = 0;
            end else if (m_mode == 0 || dir_chg) begin
                m_mode = 1; m_age = 0;
            end else if (m_mode == 1) begin
                m_age++;
                if (m_age >= 4 * (blank_code + 1)) begin m_mode = 2; m_age = 0; end
            end else if (m_mode == 2) begin
                if (trip) begin m_mode = 3; m_age = 0; end
            end else begin
                m_age++;
                if (m_age >= 8 * off_code + 7) begin m_mode = 1; m_age = 0; end
            end
        end
    end

    // Compare at the falling edge, away from the active edge
    always @(negedge clk) begin
        logic [2:0] exp_v, got_v;
        if (started && !done) begin
            exp_v[2] = (m_mode == 1 || m_mode == 2);
            exp_v[1] = (m_mode == 3) && (m_age <  8 * fast_code + 7);
            exp_v[0] = (m_mode == 3) && (m_age >= 8 * fast_code + 7);
            got_v = {drive_on, fast_decay, slow_decay};
            n_cmp++;
            if (got_v !== exp_v) begin
                n_bad++;
                $display("FAIL %s: outputs drive/fast/slow actual %b expected %b at %0t",
                         cur_req, got_v, exp_v, $time);
            end
            n_cmp++;
            if ($countones(got_v) > 1) begin
                n_bad++;
                $display("FAIL R10: outputs actual %b expected at most one set", got_v);
            end
        end
    end

    task automatic cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    // Park the bridge, then load new codes, then enable again
    task automatic reload(input int b, input int n, input int m);
        run_en = 1'b0; trip = 1'b0;
        cyc(3);
        blank_code = 2'(b); off_code = 5'(n); fast_code = 4'(m);
        run_en = 1'b1;
    endtask

    // Off-time sweep with periodic trips
    task automatic sweep(input int n, input int m);
        reload(1, n, m);
        for (int i = 0; i < 3 * (8 * n + 7) + 80; i++) begin
            trip = (i % 7 == 3);
            cyc(1);
        end
    endtask

    initial begin
        // R1: reset
        cur_req = "R1";
        cyc(5);
        rst_n = 1'b1;
        cyc(1);
        // R2: idle bit low with nonzero code, trips ignored
        cur_req = "R2";
        dac_code = 6'd20; run_en = 1'b0;
        for (int i = 0; i < 12; i++) begin trip = i[0]; cyc(1); end
        // R2: zero current code
        run_en = 1'b1; dac_code = 6'd0;
        for (int i = 0; i < 12; i++) begin trip = i[1]; cyc(1); end
        dac_code = 6'd33;
        // R3 R4 R5: each blank code with trip held high through blanking
        cur_req = "R3 R4 R5";
        for (int b = 0; b < 4; b++) begin
            reload(b, 1, 0);
            trip = 1'b1;
            cyc(60);
        end
        // R5 R6 R7 R8: off-time and decay split
        cur_req = "R5 R6 R7 R8";
        sweep(0, 0);
        sweep(31, 2);
        sweep(3, 15);
        sweep(5, 5);
        sweep(2, 9);
        sweep(6, 0);
        // R9: direction changes in all phases of the cycle
        cur_req = "R9";
        reload(2, 10, 3);
        for (int i = 0; i < 400; i++) begin
            trip = (i % 5 == 0);
            if (i % 37 == 0 || i % 53 == 0) phase = ~phase;
            cyc(1);
        end
        // R2: disable in mid cycle, then restart
        cur_req = "R2";
        for (int i = 0; i < 300; i++) begin
            trip = (i % 9 == 4);
            run_en = !(i % 41 == 20 || i % 41 == 21);
            dac_code = (i % 67 == 30) ? 6'd0 : 6'd5;
            cyc(1);
        end
        run_en = 1'b0;
        cyc(3);
        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    // Watchdog
    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            done = 1;
            n_bad++;
            $display("FAIL watchdog: run did not end, actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end
endmodule